// File: doc/BRIEF.md
# Packed SIMD Integer Execution Unit

This block executes seven packed-integer operations on 64-bit vector operands: signed greater-than mask compares on 32-bit and 16-bit lanes, signed 16-bit lane maximum, unsigned 8-bit lane maximum, a pairwise multiply-add of signed 16-bit words, and immediate-indexed word insert and word extract. One opcode byte, taken from the second byte of the instruction encoding, selects the operation. Operands come in already resolved. A memory-sourced operand is loaded onto the second vector port before issue.

Word extract returns a 32-bit integer result one cycle after issue. Every other operation returns a 64-bit vector result two cycles after issue. Results must leave in issue order. For this reason the unit lowers its ready signal when an extract is offered in the cycle right after a two-cycle operation was accepted. An unknown opcode goes down the two-cycle path. It produces a valid strobe with an illegal flag and leaves both held results untouched.

Top module: `simd_int_unit`

## Requirements
- R1: Opcode 0x66 sets each 32-bit lane of the vector result to FFFF_FFFFh when the src_a lane is greater than the src_b lane as signed values, and to 0000_0000h otherwise.
- R2: Opcode 0x65 sets each 16-bit lane to FFFFh when the src_a lane is signed-greater than the src_b lane, and to 0000h otherwise.
- R3: Opcode 0xC5 puts 16-bit lane imm[1:0] of src_b (lane 0 = bits 15:0) in res_int[15:0] and zero in res_int[31:16], with res_is_int = 1. res_vld is high in the cycle after the accepting edge.
- R4: Opcode 0xC4 returns src_a with 16-bit lane imm[1:0] replaced by int_src[15:0]. imm[7:2] and int_src[31:16] have no effect.
- R5: Opcode 0xEE returns, in each 16-bit lane, the signed maximum of the src_a and src_b lanes.
- R6: Opcode 0xDE returns, in each 8-bit lane, the unsigned maximum of the src_a and src_b lanes.
- R7: Opcode 0xF5 returns, in its low dword, a0*b0 + a1*b1, and in its high dword, a2*b2 + a3*b3. Here ak and bk are signed 16-bit lane k, and each sum wraps modulo 2^32.
- R8: Every operation except 0xC5 raises res_vld, with res_is_int = 0, exactly two cycles after the accepting edge. res_vld is low in every cycle in which no result is due.
- R9: Any other opcode raises res_vld and res_illegal two cycles after acceptance. res_vec and res_int keep their previous values.
- R10: issue_rdy is low exactly when opcode is 0xC5 and a non-0xC5 issue was accepted at the previous edge. An offer made while issue_rdy is low produces no result, and results retire in issue order.
- R11: During reset and right after it, res_vld, res_illegal, res_is_int, res_vec and res_int are zero and issue_rdy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | Offer an operation this cycle |
| opcode | input | 8 | Operation select byte |
| src_a | input | 64 | First vector operand (destination) |
| src_b | input | 64 | Second vector operand (register or loaded memory) |
| int_src | input | 32 | Integer operand for word insert |
| imm | input | 8 | Immediate; bits 1:0 index the word lane |
| issue_rdy | output | 1 | Offer is accepted when issue_vld and issue_rdy are both high |
| res_vld | output | 1 | A result retires this cycle |
| res_illegal | output | 1 | Retiring operation had an unsupported opcode |
| res_is_int | output | 1 | Retiring result is the integer result |
| res_vec | output | 64 | Most recent vector result |
| res_int | output | 32 | Most recent integer result |

## Verification
The hardest case to reach is an extract offered in the cycle right after a two-cycle operation was accepted. This is the only pattern that would make two results retire on the same edge, so it is the only one that lowers issue_rdy. The bench aims at it with directed pairs and then retries the refused extract until it is accepted. A long random run follows, weighted toward extract and with illegal opcodes mixed in. It hits the case many times, together with back-to-back long operations and an illegal result landing between two real ones. A behavioural model with a due-cycle schedule predicts ready, result order and the held values in every cycle.

// File: rtl/simd_pkg.sv
// Shared definitions for the packed SIMD integer unit.
// Assumes a 64-bit vector datapath and a 32-bit integer datapath.
package simd_pkg;
    localparam int VEC_W   = 64;
    localparam int INT_W   = 32;
    localparam int WORD_W  = 16;
    localparam int DWORD_W = 32;
    localparam int BYTE_W  = 8;
    localparam int N_WORDS  = VEC_W / WORD_W;
    localparam int N_DWORDS = VEC_W / DWORD_W;
    localparam int N_BYTES  = VEC_W / BYTE_W;
    localparam int IDX_W    = $clog2(N_WORDS);

    typedef enum logic [2:0] {
        K_GT_DW, K_GT_W, K_EXTRACT, K_INSERT,
        K_MAX_SW, K_MAX_UB, K_MADD, K_BAD
    } op_kind_t;

    // Map the opcode byte onto an operation kind.
    function automatic op_kind_t decode_op(input logic [7:0] op);
        case (op)
            8'h66:   return K_GT_DW;
            8'h65:   return K_GT_W;
            8'hC5:   return K_EXTRACT;
            8'hC4:   return K_INSERT;
            8'hEE:   return K_MAX_SW;
            8'hDE:   return K_MAX_UB;
            8'hF5:   return K_MADD;
            default: return K_BAD;
        endcase
    endfunction
endpackage

// File: rtl/simd_lane_ops.sv
// Lane-wise vector operations: compares, maxima and word insert.
// Purely combinational; the caller registers the result.
module simd_lane_ops
    import simd_pkg::*;
(
    input  op_kind_t             kind,
    input  logic [VEC_W-1:0]     a,
    input  logic [VEC_W-1:0]     b,
    input  logic [WORD_W-1:0]    ins_word,
    input  logic [IDX_W-1:0]     idx,
    output logic [VEC_W-1:0]     vec_res
);
    logic [VEC_W-1:0] gt_dw, gt_w, max_sw, max_ub, ins_v;

    for (genvar d = 0; d < N_DWORDS; d++) begin : g_dw
        assign gt_dw[d*DWORD_W +: DWORD_W] =
            ($signed(a[d*DWORD_W +: DWORD_W]) > $signed(b[d*DWORD_W +: DWORD_W]))
            ? '1 : '0;
    end

    for (genvar w = 0; w < N_WORDS; w++) begin : g_w
        logic signed [WORD_W-1:0] aw, bw;
        assign aw = a[w*WORD_W +: WORD_W];
        assign bw = b[w*WORD_W +: WORD_W];
        assign gt_w[w*WORD_W +: WORD_W]   = (aw > bw) ? '1 : '0;
        assign max_sw[w*WORD_W +: WORD_W] = (aw > bw) ? aw : bw;
        assign ins_v[w*WORD_W +: WORD_W]  = (idx == IDX_W'(w)) ? ins_word : aw;
    end

    for (genvar y = 0; y < N_BYTES; y++) begin : g_b
        assign max_ub[y*BYTE_W +: BYTE_W] =
            (a[y*BYTE_W +: BYTE_W] > b[y*BYTE_W +: BYTE_W])
            ? a[y*BYTE_W +: BYTE_W] : b[y*BYTE_W +: BYTE_W];
    end

    // Select the lane-wise result for the decoded kind.
    always_comb begin
        case (kind)
            K_GT_DW:  vec_res = gt_dw;
            K_GT_W:   vec_res = gt_w;
            K_MAX_SW: vec_res = max_sw;
            K_MAX_UB: vec_res = max_ub;
            K_INSERT: vec_res = ins_v;
            default:  vec_res = a;
        endcase
    end
endmodule

// File: rtl/simd_madd_prod.sv
// First half of the multiply-add: four signed 16x16 word products.
// Combinational; products are packed lane 0 in the low 32 bits.
module simd_madd_prod
    import simd_pkg::*;
(
    input  logic [VEC_W-1:0]             a,
    input  logic [VEC_W-1:0]             b,
    output logic [N_WORDS*DWORD_W-1:0]   prods
);
    for (genvar w = 0; w < N_WORDS; w++) begin : g_p
        logic signed [WORD_W-1:0]  aw, bw;
        logic signed [DWORD_W-1:0] p;
        assign aw = a[w*WORD_W +: WORD_W];
        assign bw = b[w*WORD_W +: WORD_W];
        assign p  = aw * bw;
        assign prods[w*DWORD_W +: DWORD_W] = p;
    end
endmodule

// File: rtl/simd_extract.sv
// Word extract: picks one word lane and zero-extends it to the integer width.
// Combinational; the index is already truncated to IDX_W bits.
module simd_extract
    import simd_pkg::*;
(
    input  logic [VEC_W-1:0]  v,
    input  logic [IDX_W-1:0]  idx,
    output logic [INT_W-1:0]  word_out
);
    // Zero-extend the selected lane.
    always_comb begin
        word_out = '0;
        word_out[WORD_W-1:0] = v[idx*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/simd_int_unit.sv
// Top of the packed SIMD integer execution unit.
// Extract retires after one edge; all other opcodes (including unsupported
// ones) pass a stage register and retire after two edges. An extract offered
// right behind a two-edge issue is refused for one cycle, keeping issue order.
module simd_int_unit
    import simd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [7:0]        opcode,
    input  logic [63:0]       src_a,
    input  logic [63:0]       src_b,
    input  logic [31:0]       int_src,
    input  logic [7:0]        imm,
    output logic              issue_rdy,
    output logic              res_vld,
    output logic              res_illegal,
    output logic              res_is_int,
    output logic [63:0]       res_vec,
    output logic [31:0]       res_int
);
    localparam int PROD_W = N_WORDS * DWORD_W;

    op_kind_t               kind;
    logic                   accept, acc_ext, acc_long;
    logic [VEC_W-1:0]       lane_res;
    logic [PROD_W-1:0]      prods;
    logic [INT_W-1:0]       ext_word;
    logic [IDX_W-1:0]       idx;

    logic                   s1_vld;
    op_kind_t               s1_kind;
    logic [VEC_W-1:0]       s1_vec;
    logic [PROD_W-1:0]      s1_prod;
    logic [VEC_W-1:0]       madd_sum;

    assign kind      = decode_op(opcode);
    assign idx       = imm[IDX_W-1:0];
    assign issue_rdy = !(s1_vld && kind == K_EXTRACT);
    assign accept    = issue_vld && issue_rdy;
    assign acc_ext   = accept && kind == K_EXTRACT;
    assign acc_long  = accept && kind != K_EXTRACT;

    simd_lane_ops u_lanes (
        .kind(kind), .a(src_a), .b(src_b),
        .ins_word(int_src[WORD_W-1:0]), .idx(idx), .vec_res(lane_res)
    );

    simd_madd_prod u_prod (.a(src_a), .b(src_b), .prods(prods));

    simd_extract u_ext (.v(src_b), .idx(idx), .word_out(ext_word));

    // Second half of the multiply-add: pairwise sums, wrapping.
    for (genvar d = 0; d < N_DWORDS; d++) begin : g_sum
        assign madd_sum[d*DWORD_W +: DWORD_W] =
            s1_prod[(2*d)*DWORD_W +: DWORD_W] + s1_prod[(2*d+1)*DWORD_W +: DWORD_W];
    end

    // Stage 1: capture two-cycle operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_kind <= K_BAD;
            s1_vec  <= '0;
            s1_prod <= '0;
        end else begin
            s1_vld <= acc_long;
            if (acc_long) begin
                s1_kind <= kind;
                s1_vec  <= lane_res;
                s1_prod <= prods;
            end
        end
    end

    // Result stage: retire an extract or the stage-1 operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld     <= 1'b0;
            res_illegal <= 1'b0;
            res_is_int  <= 1'b0;
            res_vec     <= '0;
            res_int     <= '0;
        end else if (acc_ext) begin
            res_vld     <= 1'b1;
            res_illegal <= 1'b0;
            res_is_int  <= 1'b1;
            res_int     <= ext_word;
        end else if (s1_vld) begin
            res_vld     <= 1'b1;
            res_illegal <= (s1_kind == K_BAD);
            res_is_int  <= 1'b0;
            if (s1_kind != K_BAD)
                res_vec <= (s1_kind == K_MADD) ? madd_sum : s1_vec;
        end else begin
            res_vld     <= 1'b0;
            res_illegal <= 1'b0;
            res_is_int  <= 1'b0;
        end
    end
endmodule

// File: rtl/simd_int_unit_chk.sv
// Port-level temporal checks for simd_int_unit, bound to every instance.
module simd_int_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_vld,
    input logic [7:0]  opcode,
    input logic        issue_rdy,
    input logic        res_vld,
    input logic        res_illegal,
    input logic        res_is_int,
    input logic [63:0] res_vec,
    input logic [31:0] res_int
);
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> !res_vld && !res_illegal && res_vec == '0 && res_int == '0);

    p_extract_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_rdy && opcode == 8'hC5) |=> res_vld && res_is_int);

    p_extract_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_is_int) |-> res_int[31:16] == 16'h0);

    p_long_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_rdy && opcode != 8'hC5) |=> ##1 (res_vld && !res_is_int));

    p_illegal_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_illegal) |-> $stable(res_vec) && $stable(res_int));

    p_illegal_has_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> res_vld);

    p_no_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_rdy && opcode != 8'hC5)
        |=> !(issue_vld && issue_rdy && opcode == 8'hC5));
endmodule

bind simd_int_unit simd_int_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .opcode(opcode),
    .issue_rdy(issue_rdy), .res_vld(res_vld), .res_illegal(res_illegal),
    .res_is_int(res_is_int), .res_vec(res_vec), .res_int(res_int)
);

// File: tb/simd_int_unit_test.sv
// Self-checking bench: behavioural model with a due-cycle schedule.
module simd_int_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        issue_vld = 0;
    logic [7:0]  opcode = 0;
    logic [63:0] src_a = 0, src_b = 0;
    logic [31:0] int_src = 0;
    logic [7:0]  imm = 0;
    logic        issue_rdy, res_vld, res_illegal, res_is_int;
    logic [63:0] res_vec;
    logic [31:0] res_int;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    bit last_long = 0;
    logic [63:0] exp_vec = 0;
    logic [31:0] exp_int = 0;

    typedef struct {
        bit          is_int;
        bit          bad;
        logic [63:0] v;
        logic [31:0] i;
        string       tag;
    } res_t;
    res_t sched[int];

    always #4 clk = ~clk;

    simd_int_unit uut (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .int_src(int_src), .imm(imm),
        .issue_rdy(issue_rdy), .res_vld(res_vld), .res_illegal(res_illegal),
        .res_is_int(res_is_int), .res_vec(res_vec), .res_int(res_int)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    function automatic res_t model(input logic [7:0] op, input logic [63:0] a, b,
                                   input logic [31:0] iv, input logic [7:0] im);
        res_t r;
        int k;
        r.is_int = 0; r.bad = 0; r.v = 0; r.i = 0; r.tag = "R9";
        k = int'(im % 4);
        case (op)
            8'h66: begin r.tag = "R1";
                for (int d = 0; d < 2; d++)
                    r.v[32*d +: 32] = ($signed(a[32*d +: 32]) > $signed(b[32*d +: 32])) ? 32'hFFFF_FFFF : 32'h0;
            end
            8'h65: begin r.tag = "R2";
                for (int w = 0; w < 4; w++)
                    r.v[16*w +: 16] = ($signed(a[16*w +: 16]) > $signed(b[16*w +: 16])) ? 16'hFFFF : 16'h0;
            end
            8'hC5: begin r.tag = "R3"; r.is_int = 1;
                r.i = {16'h0, b[16*k +: 16]};
            end
            8'hC4: begin r.tag = "R4";
                r.v = a; r.v[16*k +: 16] = iv[15:0];
            end
            8'hEE: begin r.tag = "R5";
                for (int w = 0; w < 4; w++)
                    r.v[16*w +: 16] = ($signed(a[16*w +: 16]) > $signed(b[16*w +: 16])) ? a[16*w +: 16] : b[16*w +: 16];
            end
            8'hDE: begin r.tag = "R6";
                for (int y = 0; y < 8; y++)
                    r.v[8*y +: 8] = (a[8*y +: 8] > b[8*y +: 8]) ? a[8*y +: 8] : b[8*y +: 8];
            end
            8'hF5: begin r.tag = "R7";
                for (int d = 0; d < 2; d++) begin
                    longint s;
                    s = longint'($signed(a[32*d +: 16])) * longint'($signed(b[32*d +: 16]))
                      + longint'($signed(a[32*d+16 +: 16])) * longint'($signed(b[32*d+16 +: 16]));
                    r.v[32*d +: 32] = s[31:0];
                end
            end
            default: r.bad = 1;
        endcase
        return r;
    endfunction

    task automatic compare_outputs();
        if (sched.exists(cyc)) begin
            res_t r;
            r = sched[cyc];
            sched.delete(cyc);
            chk(res_vld === 1'b1, {r.tag, " R8 res_vld"}, 64'(res_vld), 64'd1);
            chk(res_illegal === r.bad, "R9 res_illegal", 64'(res_illegal), 64'(r.bad));
            if (!r.bad) begin
                chk(res_is_int === r.is_int, {r.tag, " R8 res_is_int"}, 64'(res_is_int), 64'(r.is_int));
                if (r.is_int) exp_int = r.i; else exp_vec = r.v;
            end
            chk(res_vec === exp_vec, {r.tag, " res_vec"}, res_vec, exp_vec);
            chk(res_int === exp_int, {r.tag, " res_int"}, 64'(res_int), 64'(exp_int));
        end else begin
            chk(res_vld === 1'b0, "R8 R10 idle res_vld", 64'(res_vld), 64'd0);
            chk(res_vec === exp_vec && res_int === exp_int, "R10 held results",
                res_vec ^ 64'(res_int), exp_vec ^ 64'(exp_int));
        end
    endtask

    task automatic step(input bit v, input logic [7:0] op, input logic [63:0] a, b,
                        input logic [31:0] iv, input logic [7:0] im, output bit acc);
        bit rdy_m;
        issue_vld = v; opcode = op; src_a = a; src_b = b; int_src = iv; imm = im;
        #1;
        rdy_m = !(last_long && op == 8'hC5);
        chk(issue_rdy === rdy_m, "R10 issue_rdy", 64'(issue_rdy), 64'(rdy_m));
        acc = v && rdy_m;
        if (acc) sched[cyc + ((op == 8'hC5) ? 1 : 2)] = model(op, a, b, iv, im);
        last_long = acc && op != 8'hC5;
        @(posedge clk);
        cyc++;
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int j = 0; j < n; j++) step(0, 8'h00, 0, 0, 0, 0, acc);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        bit acc;
        logic [7:0] ops[7] = '{8'h66, 8'h65, 8'hC5, 8'hC4, 8'hEE, 8'hDE, 8'hF5};
        // R11: reset state
        repeat (3) @(negedge clk);
        chk(res_vld === 0 && res_illegal === 0 && res_is_int === 0, "R11 flags", {61'd0, res_vld, res_illegal, res_is_int}, 0);
        chk(res_vec === 0, "R11 res_vec", res_vec, 0);
        chk(res_int === 0, "R11 res_int", 64'(res_int), 0);
        chk(issue_rdy === 1, "R11 issue_rdy", 64'(issue_rdy), 1);
        rst_n = 1;
        idle(2);

        // Directed corner cases for each operation
        step(1, 8'h66, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_0001, 0, 0, acc); // R1 sign and equal
        step(1, 8'h65, 64'hFFFF_0001_8000_7FFF, 64'h0000_0001_7FFF_8000, 0, 0, acc); // R2
        idle(2);
        step(1, 8'hC5, 0, 64'h4444_3333_2222_1111, 0, 8'hFE, acc); // R3 high imm bits ignored, lane 2
        step(1, 8'hC5, 0, 64'hC444_3333_2222_1111, 0, 8'h03, acc); // R3 lane 3
        step(1, 8'hC4, 64'hAAAA_BBBB_CCCC_DDDD, 0, 32'h5A5A_1234, 8'hFD, acc); // R4 lane 1
        step(1, 8'hEE, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0000_FFFF, 0, 0, acc); // R5
        step(1, 8'hDE, 64'h80FF_0001_7F00_10EF, 64'h7F00_FF01_8001_20FE, 0, 0, acc); // R6
        step(1, 8'hF5, 64'h8000_8000_7FFF_FFFF, 64'h8000_8000_7FFF_0002, 0, 0, acc); // R7 wrap to 8000_0000
        step(1, 8'h0F, 64'h1234, 64'h5678, 0, 0, acc); // R9 illegal
        step(1, 8'hC5, 0, 64'h0000_0000_0000_BEEF, 0, 0, acc); // R10 stall
        chk(!acc, "R10 refused extract", 64'(acc), 0);
        step(1, 8'hC5, 0, 64'h0000_0000_0000_BEEF, 0, 0, acc);
        chk(acc, "R10 retried extract", 64'(acc), 1);
        step(1, 8'hF5, 64'h0003_0002_FFFF_0004, 64'h0005_0006_0007_FFF8, 0, 0, acc); // R7 after extract
        idle(3);

        // Random mix, weighted toward extract, with unsupported opcodes
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] op;
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 7) op = ops[sel];
            else if (sel == 7) op = 8'hC5;
            else op = 8'($urandom);
            step(($urandom_range(0, 4) != 0), op, {$urandom, $urandom}, {$urandom, $urandom},
                 $urandom, 8'($urandom), acc);
        end
        idle(3);
        finish_run();
    end
endmodule